// File: doc/BRIEF.md
# Serial Interrupt Slave Agent

This block is the peripheral side of a shared, wired-OR serial interrupt line. It watches the line and finds the end of each start pulse. From that point it counts frames of three clocks each: sample, recovery and turn-around. Each interrupt input is assigned to one frame by a slot map. In that frame the agent pulls the line low if the input is low. It drives the line high for one recovery clock after it has pulled it low, and then releases it. Every cycle is served in this way, whichever agent started it.

The agent has no programmable state. It learns the cycle mode by measuring the low time of the stop pulse that ends each cycle. In quiet mode it may request a cycle by pulling the idle line low for a single clock. It does so when an input differs from the value it last delivered. In continuous mode it stays passive and waits for the host.

Top module: `sirq_agent`

## Requirements
- R1: After reset the agent releases the line (bus_oe_o=0) and is in continuous mode. An input change then starts no cycle until a stop pulse of 2 clocks has been seen.
- R2: The first high clock after a low pulse of 4 or more clocks is clock 0, and the sample phase of frame k (counted from 0) is clock 3k+2. Input i belongs to the frame held in slot_map_i[5i+4:5i]. In that sample phase the agent drives low (bus_oe_o=1, bus_do_o=0) exactly when an input mapped to the frame was low at the clock edge that opens the phase.
- R3: The agent drives high (bus_oe_o=1, bus_do_o=1) in the clock after a sample phase only if it drove low in that sample phase. In turn-around clocks and in frames that are not assigned to it, the line is released.
- R4: Inputs that share a frame produce one low drive when any of them is low.
- R5: After the frame count has passed the highest assigned frame, a low pulse of 2 clocks selects quiet mode and a low pulse of 3 clocks selects continuous mode.
- R6: In quiet mode, with the line idle and some input differing from the value last delivered, the agent drives low for exactly one clock and never drives high during the request. The earliest such clock is the second clock after the stop pulse rises.
- R7: No request is made while a cycle is active. A change that is still delivered in its own frame of the current cycle causes no request after that cycle.
- R8: Start pulses of 4 to 8 clocks are all accepted. Single-clock lows from other agents inside a cycle do not disturb the frame count.
- R9: In continuous mode the agent never requests a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_i | input | 1 | Sampled level of the serial line |
| bus_oe_o | output | 1 | Drive enable for the line |
| bus_do_o | output | 1 | Value driven when enabled |
| irq_i | input | NUM_IRQ | Interrupt input levels, active low |
| slot_map_i | input | NUM_IRQ*SLOT_W | Frame index per input, 5 bits each |

## Verification
Two functions can land on the same clock edge. One is the sampling of an input into its own frame. The other is the change detection that feeds the quiet-mode request. The bench toggles an input in the turn-around clock just before that input's sample phase, so the edge that latches the drive decision also sees the new level. It then judges the outcome from the ports: the new level must appear on the line in that frame, and no request may follow the stop pulse. A second case changes an input after its frame has passed. For that case the request must land exactly on the second clock after the stop pulse rises, and not one clock earlier.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  typedef enum logic [1:0] {
    PH_SAMP  = 2'd0,
    PH_RECOV = 2'd1,
    PH_TURN  = 2'd2
  } phase_e;

  localparam int unsigned START_MIN = 4;
  localparam int unsigned STOP_QUIET = 2;
  localparam int unsigned STOP_CONT = 3;
endpackage

// File: rtl/sirq_pulse_meter.sv
module sirq_pulse_meter
  import sirq_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic idle_o,
  output logic start_o,
  output logic qstop_o,
  output logic cstop_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] low_q;
  logic             rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               low_q <= '0;
    else if (line_i)           low_q <= '0;
    else if (low_q != CNT_MAX) low_q <= low_q + 1'b1;
  end

  assign rise    = line_i && (low_q != '0);
  assign idle_o  = line_i && (low_q == '0);
  assign start_o = rise && (low_q >= CNT_W'(START_MIN));
  assign qstop_o = rise && (low_q == CNT_W'(STOP_QUIET));
  assign cstop_o = rise && (low_q == CNT_W'(STOP_CONT));

  AST_LOW_COUNTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_i |=> (low_q != '0)); // R8
  AST_ONE_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({start_o, qstop_o, cstop_o}) <= 1); // R5
endmodule

// File: rtl/sirq_frame_seq.sv
module sirq_frame_seq
  import sirq_pkg::*;
#(
  parameter int unsigned FW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          qstop_i,
  input  logic          cstop_i,
  input  logic [FW-1:0] max_slot_i,
  output logic          active_o,
  output phase_e        phase_o,
  output logic          to_samp_o,
  output logic [FW-1:0] next_frame_o,
  output logic          quiet_o
);
  localparam logic [FW-1:0] FMAX = '1;

  logic          active_q, lead_q, quiet_q, stop_ok;
  phase_e        ph_q;
  logic [FW-1:0] frame_q;

  assign stop_ok      = active_q && (frame_q > max_slot_i) && (qstop_i || cstop_i);
  assign to_samp_o    = active_q && !start_i && !stop_ok && (ph_q == PH_TURN);
  assign next_frame_o = (lead_q || frame_q == FMAX) ? frame_q : frame_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      lead_q   <= 1'b0;
      quiet_q  <= 1'b0;
      ph_q     <= PH_TURN;
      frame_q  <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      lead_q   <= 1'b1;
      ph_q     <= PH_TURN;
      frame_q  <= '0;
    end else if (stop_ok) begin
      active_q <= 1'b0;
      quiet_q  <= qstop_i;
    end else if (active_q) begin
      unique case (ph_q)
        PH_SAMP:  ph_q <= PH_RECOV;
        PH_RECOV: ph_q <= PH_TURN;
        default: begin
          ph_q    <= PH_SAMP;
          lead_q  <= 1'b0;
          frame_q <= next_frame_o;
        end
      endcase
    end
  end

  assign active_o = active_q;
  assign phase_o  = ph_q;
  assign quiet_o  = quiet_q;

  AST_SAMP_TO_RECOV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && ph_q == PH_SAMP && !start_i && !stop_ok) |=> (ph_q == PH_RECOV)); // R3
  AST_MODE_AT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_q != $past(quiet_q)) |-> $past(active_q)); // R5
endmodule

// File: rtl/sirq_slot_drive.sv
module sirq_slot_drive
  import sirq_pkg::*;
#(
  parameter int unsigned N  = 4,
  parameter int unsigned SW = 5,
  parameter int unsigned FW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  irq_i,
  input  logic [N*SW-1:0] slot_map_i,
  input  logic          start_i,
  input  logic          active_i,
  input  phase_e        phase_i,
  input  logic          to_samp_i,
  input  logic [FW-1:0] next_frame_i,
  output logic [FW-1:0] max_slot_o,
  output logic          drv_oe_o,
  output logic          drv_do_o,
  output logic          change_o
);
  logic [N-1:0] hit, sent_q;
  logic         drv_q;

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign hit[i] = to_samp_i && ({1'b0, slot_map_i[i*SW +: SW]} == next_frame_i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sent_q[i] <= 1'b1;
      else if (hit[i]) sent_q[i] <= irq_i[i];
    end
  end

  always_comb begin
    max_slot_o = '0;
    for (int i = 0; i < N; i++)
      if ({1'b0, slot_map_i[i*SW +: SW]} > max_slot_o) max_slot_o = {1'b0, slot_map_i[i*SW +: SW]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        drv_q <= 1'b0;
    else if (start_i)   drv_q <= 1'b0;
    else if (to_samp_i) drv_q <= |(hit & ~irq_i);
  end

  assign drv_oe_o = active_i && drv_q && (phase_i == PH_SAMP || phase_i == PH_RECOV);
  assign drv_do_o = (phase_i == PH_RECOV);
  assign change_o = |(irq_i ^ sent_q);

  AST_LOW_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_oe_o && phase_i == PH_SAMP) |-> |(~$past(irq_i))); // R2
  AST_RECOV_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_oe_o && !drv_do_o && !start_i) |=> (drv_oe_o && drv_do_o)); // R3
endmodule

// File: rtl/sirq_agent.sv
module sirq_agent
  import sirq_pkg::*;
#(
  parameter int unsigned NUM_IRQ  = 4,
  parameter int unsigned SLOT_W   = 5,
  parameter int unsigned LOWCNT_W = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      bus_i,
  output logic                      bus_oe_o,
  output logic                      bus_do_o,
  input  logic [NUM_IRQ-1:0]        irq_i,
  input  logic [NUM_IRQ*SLOT_W-1:0] slot_map_i
);
  localparam int unsigned FRAME_W = SLOT_W + 1;

  logic               idle, start, qstop, cstop;
  logic               active, to_samp, quiet, change, drv_oe, drv_do, req_q;
  phase_e             phase;
  logic [FRAME_W-1:0] next_frame, max_slot;

  sirq_pulse_meter #(.CNT_W(LOWCNT_W)) u_meter (
    .clk_i, .rst_ni, .line_i(bus_i),
    .idle_o(idle), .start_o(start), .qstop_o(qstop), .cstop_o(cstop)
  );

  sirq_frame_seq #(.FW(FRAME_W)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .qstop_i(qstop), .cstop_i(cstop),
    .max_slot_i(max_slot), .active_o(active), .phase_o(phase),
    .to_samp_o(to_samp), .next_frame_o(next_frame), .quiet_o(quiet)
  );

  sirq_slot_drive #(.N(NUM_IRQ), .SW(SLOT_W), .FW(FRAME_W)) u_drive (
    .clk_i, .rst_ni, .irq_i, .slot_map_i, .start_i(start), .active_i(active),
    .phase_i(phase), .to_samp_i(to_samp), .next_frame_i(next_frame),
    .max_slot_o(max_slot), .drv_oe_o(drv_oe), .drv_do_o(drv_do), .change_o(change)
  );

  // one-clock start request, only on an idle line in quiet mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                req_q <= 1'b0;
    else if (req_q)                             req_q <= 1'b0;
    else if (quiet && !active && idle && change) req_q <= 1'b1;
  end

  assign bus_oe_o = req_q || drv_oe;
  assign bus_do_o = !req_q && drv_do;

  AST_REQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q); // R6
  AST_REQ_NOT_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> !active); // R7
  AST_REQ_QUIET_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> quiet); // R9
  AST_TURN_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && phase == PH_TURN) |-> !bus_oe_o); // R3
endmodule

// File: tb/sim_sirq_agent.sv
module sim_sirq_agent;
  localparam int N = 4;
  localparam int NF = 8;

  logic clk = 1'b0;
  logic rst_n, host_low;
  logic [N-1:0] irq;
  logic [N*5-1:0] map;
  logic line, oe, dout;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;
  assign map = {5'd6, 5'd3, 5'd3, 5'd1};
  assign line = !((oe && !dout) || host_low);

  sirq_agent u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_i(line), .bus_oe_o(oe), .bus_do_o(dout),
    .irq_i(irq), .slot_map_i(map)
  );

  function automatic int slot_of(input int i);
    case (i) 0: return 1; 1: return 3; 2: return 3; default: return 6; endcase
  endfunction

  function automatic bit exp_drive(input int k);
    for (int i = 0; i < N; i++) if (slot_of(i) == k && !irq[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic samp();
    @(negedge clk);
  endtask

  task automatic host_cycle(input int sw, input int stw, input bit agent, input bit other,
                            input int chg_step, input int chg_idx);
    bit e;
    if (!agent) begin
      for (int j = 0; j < 2; j++) begin
        step(); host_low = 1'b0; samp();
        chk(!oe, "R9 R7 no request before host start", oe, 0);
      end
    end
    for (int j = 0; j < sw; j++) begin step(); host_low = 1'b1; end
    step(); host_low = 1'b0;
    step();
    for (int k = 0; k < NF; k++) begin
      step();
      e = exp_drive(k);
      host_low = other && (k == 5);
      if (chg_step == 3*k) irq[chg_idx] = ~irq[chg_idx];
      samp();
      chk(oe == e && (!e || !dout), "R2 R4 R8 sample drive", {oe, dout}, {e, 1'b0});
      chk(line == !(e || (other && k == 5)), "R2 line level", line, !(e || (other && k == 5)));
      step(); host_low = 1'b0;
      if (chg_step == 3*k+1) irq[chg_idx] = ~irq[chg_idx];
      samp();
      chk(oe == e && (!e || dout), "R3 recovery", {oe, dout}, {e, e});
      step();
      if (chg_step == 3*k+2) irq[chg_idx] = ~irq[chg_idx];
      samp();
      chk(!oe, "R3 turn-around release", oe, 0);
    end
    for (int j = 0; j < stw; j++) begin step(); host_low = 1'b1; end
    step(); host_low = 1'b0;
  endtask

  task automatic expect_request(input string tag);
    step(); samp(); chk(!oe, {tag, " not before 2nd clock"}, oe, 0);
    step(); samp(); chk(oe && !dout, {tag, " one-clock low"}, {oe, dout}, 2);
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_low = 1'b0; irq = '1;
    repeat (3) step();
    samp(); chk(!oe, "R1 reset release", oe, 0);
    step(); rst_n = 1'b1;
    irq[0] = 1'b0;
    for (int j = 0; j < 8; j++) begin
      step(); samp(); chk(!oe, "R1 no request after reset", oe, 0);
    end
    irq = '1;
    // sweep of start widths and input patterns in continuous mode
    for (int sw = 4; sw <= 8; sw++)
      for (int p = 0; p < 16; p++) begin
        irq = N'(p);
        host_cycle(sw, 3, 1'b0, p[0], -1, 0);
      end
    // quiet mode entry, idle request
    irq = 4'b1010;
    host_cycle(4, 2, 1'b0, 1'b0, -1, 0);
    for (int j = 0; j < 4; j++) begin
      step(); samp(); chk(!oe, "R6 no request without change", oe, 0);
    end
    step(); irq[0] = ~irq[0]; samp();
    chk(!oe, "R6 request not before change seen", oe, 0);
    step(); samp(); chk(oe && !dout, "R6 idle request", {oe, dout}, 2);
    host_cycle(3, 2, 1'b1, 1'b0, -1, 0);
    // change after its frame: request after stop (R5 quiet)
    host_cycle(6, 2, 1'b0, 1'b0, 3*5, 0);
    expect_request("R5 R6 R7");
    host_cycle(5, 2, 1'b1, 1'b0, -1, 0);
    // change before its frame: delivered, no request
    host_cycle(5, 2, 1'b0, 1'b0, 0, 0);
    // change in the clock before its own sample phase
    host_cycle(7, 2, 1'b0, 1'b0, 3*5+2, 3);
    host_cycle(8, 3, 1'b0, 1'b0, -1, 0);
    // continuous again: no requests
    irq = ~irq;
    for (int j = 0; j < 12; j++) begin
      step(); samp(); chk(!oe, "R5 R9 continuous silent", oe, 0);
    end
    host_cycle(4, 3, 1'b0, 1'b0, -1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule